// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Controller

This block owns a peripheral's two-bit control word: a reset-hold bit that keeps the peripheral in synchronous reset, and a clock-gate bit that stops its clock. Software changes these bits in one of three ways. A plain write replaces both bits. A set write turns on the bits marked in the data. A clear write turns off the bits marked in the data.

Raising the reset-hold bit does not stop the clock at once. The peripheral keeps its clock for a programmable number of cycles, so its synchronous reset can take effect. After that the controller raises the clock-gate bit by itself. Software polls for this bit as a handshake. To bring the peripheral back, software first drops the reset-hold bit and then clears the clock-gate bit. Any attempt to clear the gate while reset is still held is ignored. The block drives two outputs: an active-high reset to the peripheral logic, and an enable for an external clock-gating cell.

Top module: `softrst_clkgate_ctrl`

## Requirements
- R1: When `rst_n` is low at a clock edge, the reset-hold bit and the clock-gate bit both become 1 from that edge on. So `periph_rst` is 1 and `clk_en` is 0.
- R2: A write with `wr_op` = 0 loads the reset-hold bit from `wr_data[31]` and the clock-gate bit from `wr_data[30]`, subject to R5. The new values are visible right after the clock edge that samples `wr_en`.
- R3: A write with `wr_op` = 1 sets only the bits among 31 and 30 that are 1 in `wr_data`. A write with `wr_op` = 2 clears only those bits. The other control bit keeps its value.
- R4: While the reset-hold bit is 1 and the gate bit is 0, the gate bit becomes 1 by itself exactly `GATE_DELAY` clock edges after the edge that raised the reset-hold bit.
- R5: While the reset-hold bit is 1 before a write edge, no write can clear the gate bit. This holds even for a write that drops the reset-hold bit in the same edge.
- R6: When the reset-hold bit is 0, a clear of the gate bit takes effect at the next edge, and `clk_en` returns to 1.
- R7: `periph_rst` equals the reset-hold bit and `clk_en` equals the inverse of the gate bit. `rd_data` shows the reset-hold bit at bit 31 and the gate bit at bit 30, and reads 0 in every other bit.
- R8: A write with `wr_op` = 3 changes nothing.
- R9: With the reset-hold bit at 0, software can set the gate bit. It then stays set, and the reset-hold bit stays 0, until software writes again.
- R10: If the reset-hold bit drops before the delay runs out, the gate bit does not rise on its own.
- R11: Every new rise of the reset-hold bit starts the full `GATE_DELAY` count again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_op | input | 2 | 0 plain write, 1 set, 2 clear, 3 no effect |
| wr_data | input | DATA_W | Write data; bit 31 reset-hold, bit 30 clock gate |
| rd_data | output | DATA_W | Control word readback |
| periph_rst | output | 1 | Synchronous reset to the peripheral, active high |
| clk_en | output | 1 | Enable for the peripheral's clock-gating cell |

## Verification
A software write is due one clock edge after the edge that samples `wr_en`. The gate bit that hardware raises is due `GATE_DELAY` edges after the edge that raised reset-hold. The bench counts every edge. For each write, the driver queues the cycle in which each result must appear. The monitor compares the outputs on the falling edge of exactly that cycle, so an early result and a late result both fail. The checks also cover the cycle just before the hardware-set gate is due, so a delay that is off by one is caught. Any result still queued after its cycle has passed is counted as missed.

// File: rtl/srcg_pkg.sv
// Package: shared types for the soft-reset / clock-gate controller.
// Assumes the write operation code is two bits wide.
package srcg_pkg;

    // Write operation applied to the control word.
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

    // The two architected control bits.
    typedef struct packed {
        logic hold;   // peripheral held in reset
        logic gate;   // peripheral clock stopped
    } ctl_bits_t;

endpackage

// File: rtl/srcg_wr_decode.sv
// Module: srcg_wr_decode
// Turns a software write (plain, set or clear) into the requested next value
// of the control bits. It does not apply the gate-clear rule or the hardware
// gate set; srcg_ctl_state does that. Purely combinational.
// Assumes HOLD_BIT and GATE_BIT are distinct positions below DATA_W.
module srcg_wr_decode
    import srcg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int HOLD_BIT = 31,
    parameter int GATE_BIT = 30
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  ctl_bits_t         cur,
    output ctl_bits_t         sw_next
);

    wr_op_e op;
    logic   hold_sel;
    logic   gate_sel;
    logic   unused_data;

    assign op          = wr_op_e'(wr_op);
    assign hold_sel    = wr_data[HOLD_BIT];
    assign gate_sel    = wr_data[GATE_BIT];
    assign unused_data = ^wr_data;

    // Compute the software-requested control bits for this cycle.
    always_comb begin
        sw_next = cur;
        if (wr_en) begin
            unique case (op)
                OP_WRITE: begin
                    sw_next.hold = hold_sel;
                    sw_next.gate = gate_sel;
                end
                OP_SET: begin
                    if (hold_sel) sw_next.hold = 1'b1;
                    if (gate_sel) sw_next.gate = 1'b1;
                end
                OP_CLEAR: begin
                    if (hold_sel) sw_next.hold = 1'b0;
                    if (gate_sel) sw_next.gate = 1'b0;
                end
                default: sw_next = cur;
            endcase
        end
    end

endmodule

// File: rtl/srcg_gate_timer.sv
// Module: srcg_gate_timer
// Counts the clock cycles spent in reset-hold while the clock is still running.
// It pulses fire in the cycle before the gate bit must rise, so the gate is
// set GATE_DELAY edges after the edge that raised hold.
// Assumes GATE_DELAY >= 1.
module srcg_gate_timer #(
    parameter int GATE_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic gate,
    output logic fire
);

    localparam int CNT_W = (GATE_DELAY > 1) ? $clog2(GATE_DELAY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GATE_DELAY - 1);

    logic [CNT_W-1:0] cnt_q;

    assign fire = hold && !gate && (cnt_q == LAST);

    // Advance the delay count while in reset with the clock running; restart it when hold is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold) begin
            cnt_q <= '0;
        end else if (!gate && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the count never passes the programmed delay
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R11 / R10: dropping hold restarts the count from zero
    a_r11_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (cnt_q == '0));

endmodule

// File: rtl/srcg_ctl_state.sv
// Module: srcg_ctl_state
// Holds the two control bits. It applies the software request, the rule
// that the gate cannot be cleared while reset-hold is high, and the
// hardware gate set from the timer.
// Assumes sw_next already reflects this cycle's write (if any).
module srcg_ctl_state
    import srcg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t sw_next,
    input  logic      fire,
    output ctl_bits_t ctl_q
);

    ctl_bits_t ctl_d;

    // Merge the software request with the gate-hold rule and the hardware set.
    always_comb begin
        ctl_d.hold = sw_next.hold;
        ctl_d.gate = sw_next.gate | fire | (ctl_q.hold & ctl_q.gate);
    end

    // Register the control bits; reset leaves the peripheral in reset and gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{hold: 1'b1, gate: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R5: a gate that is set while in reset stays set through the next edge
    a_r5_gate_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.hold && ctl_q.gate) |=> ctl_q.gate);

    // R4: the timer only fires while hold is high and the gate is still open
    a_r4_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ctl_q.gate);

endmodule

// File: rtl/softrst_clkgate_ctrl.sv
// Module: softrst_clkgate_ctrl (top)
// Control word for one peripheral's soft reset and clock gate. Writes take
// effect one edge after wr_en. The gate bit rises by itself GATE_DELAY edges
// after reset-hold goes high.
// Assumes one write per cycle and an external clock-gating cell driven by clk_en.
module softrst_clkgate_ctrl
    import srcg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int HOLD_BIT   = 31,
    parameter int GATE_BIT   = 30,
    parameter int GATE_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_op,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              periph_rst,
    output logic              clk_en
);

    ctl_bits_t sw_next;
    ctl_bits_t ctl_q;
    logic      fire;

    srcg_wr_decode #(
        .DATA_W  (DATA_W),
        .HOLD_BIT(HOLD_BIT),
        .GATE_BIT(GATE_BIT)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_op  (wr_op),
        .wr_data(wr_data),
        .cur    (ctl_q),
        .sw_next(sw_next)
    );

    srcg_gate_timer #(
        .GATE_DELAY(GATE_DELAY)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (ctl_q.hold),
        .gate (ctl_q.gate),
        .fire (fire)
    );

    srcg_ctl_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_next(sw_next),
        .fire   (fire),
        .ctl_q  (ctl_q)
    );

    // Drive the readback word and the two peripheral controls from the state.
    always_comb begin
        rd_data           = '0;
        rd_data[HOLD_BIT] = ctl_q.hold;
        rd_data[GATE_BIT] = ctl_q.gate;
        periph_rst        = ctl_q.hold;
        clk_en            = ~ctl_q.gate;
    end

    // R7: the reset output and clock enable agree with the readback
    a_r7_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rst == rd_data[HOLD_BIT]) && (clk_en != rd_data[GATE_BIT]));

    // R8: the reserved op leaves reset-hold untouched
    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_op == 2'd3)) |=> $stable(periph_rst));

    // R9 / R10: out of reset and with no write, the gate never changes
    a_r10_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_rst && !wr_en) |=> $stable(clk_en));

    // R1: one edge after reset, the peripheral is in reset and gated
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (periph_rst && !clk_en));

endmodule

// File: tb/softrst_clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module softrst_clkgate_ctrl_tb_top;

    localparam int D  = 4;
    localparam int DW = 32;
    localparam logic [DW-1:0] HOLD_M = 32'h8000_0000;
    localparam logic [DW-1:0] GATE_M = 32'h4000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_op = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          periph_rst;
    logic          clk_en;

    int cyc = 0;
    int mon_checks = 0;
    int mon_errs = 0;

    typedef struct {
        int    due;
        logic  hold;
        logic  gate;
        string req;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    softrst_clkgate_ctrl #(.GATE_DELAY(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
        .wr_data(wr_data), .rd_data(rd_data), .periph_rst(periph_rst), .clk_en(clk_en)
    );

    // Monitor: pop every expectation due this cycle and compare (R7 checked on each).
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                mon_checks++;
                if (rd_data[31] !== sbq[i].hold || rd_data[30] !== sbq[i].gate ||
                    rd_data[29:0] !== '0 || periph_rst !== sbq[i].hold ||
                    clk_en !== ~sbq[i].gate) begin
                    mon_errs++;
                    $display("FAIL %s/R7 cyc=%0d: rd=%h rst=%b en=%b, expected hold=%b gate=%b en=%b",
                             sbq[i].req, cyc, rd_data, periph_rst, clk_en,
                             sbq[i].hold, sbq[i].gate, ~sbq[i].gate);
                end
                sbq.delete(i);
            end else if (sbq[i].due < cyc) begin
                mon_checks++;
                mon_errs++;
                $display("FAIL %s missed at cyc=%0d: actual none, expected due %0d",
                         sbq[i].req, cyc, sbq[i].due);
                sbq.delete(i);
            end
        end
    end

    task automatic expect_in(input int k, input logic h, input logic g, input string req);
        exp_t e;
        e.due = cyc + k; e.hold = h; e.gate = g; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic begin_write(input logic [1:0] op, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_op = op; wr_data = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0; wr_op = 2'd0; wr_data = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        expect_in(1, 1'b1, 1'b1, "R1");
        expect_in(2, 1'b1, 1'b1, "R1");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic run_tests();
        do_reset();
        // R6: proper bring-up order, hold first, then gate
        begin_write(2'd2, HOLD_M); expect_in(1, 1'b0, 1'b1, "R6");
        idle(3);
        begin_write(2'd2, GATE_M); expect_in(1, 1'b0, 1'b0, "R6"); expect_in(3, 1'b0, 1'b0, "R6");
        idle(4);
        // R4: set hold, gate rises exactly D edges later
        begin_write(2'd1, HOLD_M);
        expect_in(1, 1'b1, 1'b0, "R3");
        expect_in(D, 1'b1, 1'b0, "R4");
        expect_in(D + 1, 1'b1, 1'b1, "R4");
        idle(D + 3);
        // R5: clearing the gate while in reset is ignored
        begin_write(2'd2, GATE_M); expect_in(1, 1'b1, 1'b1, "R5");
        begin_write(2'd0, HOLD_M); expect_in(1, 1'b1, 1'b1, "R5");
        idle(1);
        begin_write(2'd2, HOLD_M | GATE_M); expect_in(1, 1'b0, 1'b1, "R5");
        idle(2);
        begin_write(2'd2, GATE_M); expect_in(1, 1'b0, 1'b0, "R6");
        idle(1);
        // R10: drop hold before the delay runs out
        begin_write(2'd1, HOLD_M); expect_in(1, 1'b1, 1'b0, "R10");
        idle(1);
        begin_write(2'd2, HOLD_M); expect_in(1, 1'b0, 1'b0, "R10"); expect_in(5, 1'b0, 1'b0, "R10");
        idle(6);
        // R11: a new rise of hold waits the full delay again
        begin_write(2'd1, HOLD_M);
        expect_in(D, 1'b1, 1'b0, "R11");
        expect_in(D + 1, 1'b1, 1'b1, "R11");
        idle(D + 3);
        begin_write(2'd2, HOLD_M); idle(2);
        begin_write(2'd2, GATE_M); expect_in(1, 1'b0, 1'b0, "R6");
        idle(1);
        // R9: software gate set with hold low stays put
        begin_write(2'd1, GATE_M); expect_in(1, 1'b0, 1'b1, "R9"); expect_in(6, 1'b0, 1'b1, "R9");
        idle(7);
        begin_write(2'd2, GATE_M); expect_in(1, 1'b0, 1'b0, "R6");
        idle(1);
        // R8: reserved op with all ones changes nothing
        begin_write(2'd3, '1); expect_in(1, 1'b0, 1'b0, "R8"); expect_in(6, 1'b0, 1'b0, "R8");
        idle(7);
        // R2: plain write loads both bits
        begin_write(2'd0, HOLD_M); expect_in(1, 1'b1, 1'b0, "R2"); expect_in(D + 1, 1'b1, 1'b1, "R2");
        idle(D + 2);
        begin_write(2'd0, '0); expect_in(1, 1'b0, 1'b1, "R5");
        begin_write(2'd0, '0); expect_in(1, 1'b0, 1'b0, "R2");
        idle(1);
        // R3: aliases touch only the selected bit
        begin_write(2'd1, GATE_M); expect_in(1, 1'b0, 1'b1, "R3");
        begin_write(2'd1, HOLD_M); expect_in(1, 1'b1, 1'b1, "R3");
        idle(1);
        begin_write(2'd2, HOLD_M); expect_in(1, 1'b0, 1'b1, "R3");
        begin_write(2'd2, GATE_M); expect_in(1, 1'b0, 1'b0, "R3");
        idle(2);
        // R1: reset in the middle of operation
        do_reset();
        idle(4);
    endtask

    initial begin
        bit timed_out = 1'b0;
        int errs;
        int checks;
        fork
            run_tests();
            begin
                repeat (5000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        @(negedge clk);
        errs = mon_errs + sbq.size();
        checks = mon_checks + sbq.size();
        if (sbq.size() != 0) $display("FAIL %s pending: actual none, expected due %0d", sbq[0].req, sbq[0].due);
        if (timed_out) begin
            errs++; checks++;
            $display("FAIL watchdog: actual hung, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule